// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 28 thirty-two-bit control words, reached over a simple word-wide bus with a byte offset, a write strobe and write data. Reads are combinational on the offset. Most words are plain storage that software sets up and other logic reads. The interrupt enable word is never written directly. It changes only through a companion pair of words, where a write of ones sets bits and another write of ones clears them. The enable word and the interrupt status word both ignore direct writes.

One bit of the general configuration word works as a software reset trigger. A write that takes that bit from 0 to 1 raises a one-cycle system reset request. A few words feed neighbouring logic directly as output ports: the configuration window map, the interrupt edge mask, the interrupt polarity mask and the live enable mask. Several words come out of reset with fixed non-zero values.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset the words read as follows. Offset 0x00 reads 0x00000C40 and 0x04 reads 0x00001384 (bits 2, 7, 8, 9 and 12 set). Offset 0x08 reads 0x2BFF8010 and 0x0C reads 0x255E0091. Offset 0x10 reads 0x00006140. Offsets 0x1C and 0x20 each read 0x000001FF. Offset 0x68 reads 0x00000008 and 0x6C reads 0x10000000. Every other defined word reads 0.
- R2: A write to offset 0x30 stores the value at 0x30. In the same cycle it ORs the value into the enable word at 0x38.
- R3: A write to offset 0x34 stores the value at 0x34. In the same cycle it clears, in the enable word, every bit that is 1 in the value.
- R4: Writes to 0x38 (enable) and to 0x3C (interrupt status) change nothing. The status word reads 0.
- R5: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, raises `sysResetReq` for exactly the one cycle after the write edge. The written value is stored as usual.
- R6: A write to 0x04 that leaves bit 2 at 0, or that finds bit 2 already 1, raises no request. No write to any other offset raises a request.
- R7: Every other defined offset from 0x00 to 0x6C stores a full word on write. A read of a defined offset returns its stored word in the same cycle.
- R8: Offsets 0x70 to 0x7C are undefined. Writes there are dropped and reads return 0.
- R9: An access whose offset has bits [1:0] non-zero is not a full-word access. Such a write is dropped and such a read returns 0.
- R10: `mapCfg`, `edgeMask`, `polMask` and `intEnable` always equal the stored words at 0x18, 0x24, 0x2C and 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 7 | Byte offset of the access |
| busWrite | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| sysResetReq | output | 1 | One-cycle system reset request |
| mapCfg | output | 32 | Configuration window map word |
| edgeMask | output | 32 | Interrupt edge-select mask |
| polMask | output | 32 | Interrupt polarity mask |
| intEnable | output | 32 | Live interrupt enable mask |

## Verification
The assertions assume that `busWrite` is a clean one-cycle-per-access strobe, that the offset and data are steady around each rising edge, and that the bus is idle while reset is held. The bench drives every input on the falling edge and releases reset at a falling edge with the strobe low, so these assumptions hold. It sweeps every word offset of the 7-bit space, including the undefined tail. It also sends misaligned offsets, so the rules for dropped and zero-read accesses are exercised under the same bus discipline.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 28;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int ADDR_W    = IDX_W + 2;

  // word indices whose behaviour is special
  localparam int W_GEN  = 1;
  localparam int W_MAP  = 6;
  localparam int W_EDGE = 9;
  localparam int W_POL  = 11;
  localparam int W_SET  = 12;
  localparam int W_CLR  = 13;
  localparam int W_EN   = 14;
  localparam int W_ISR  = 15;

  localparam int SELF_RESET_BIT = 2;

  typedef struct packed {
    logic             store;  // plain full-word store into word idx
    logic [IDX_W-1:0] idx;
    logic             enSet;  // OR data into enable word
    logic             enClr;  // clear data bits in enable word
    logic             rdHit;  // offset is an aligned, defined word
  } strobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input int unsigned w);
    logic [DATA_W-1:0] v;
    case (w)
      0:       v = 32'h0000_0C40;
      1:       v = 32'h0000_1384;
      2:       v = 32'h2BFF_8010;
      3:       v = 32'h255E_0091;
      4:       v = 32'h0000_6140;
      7:       v = 32'h0000_01FF;
      8:       v = 32'h0000_01FF;
      26:      v = 32'h0000_0008;
      27:      v = 32'h1000_0000;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrite,
  input  logic          newSelfReset,
  input  logic          oldSelfReset,
  output strobe_t       stb,
  output logic          resetPulse
);
  localparam int IW = AW - 2;

  logic          aligned;
  logic          defined;
  logic [IW-1:0] wordIdx;
  logic          roWord;
  logic          resetEdge;

  assign wordIdx = busAddr[AW-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign defined = (int'(wordIdx) < NUM_WORDS);
  assign roWord  = (int'(wordIdx) == W_EN) || (int'(wordIdx) == W_ISR);

  always_comb begin
    stb.idx   = wordIdx;
    stb.rdHit = aligned && defined;
    stb.store = busWrite && aligned && defined && !roWord;
    stb.enSet = stb.store && (int'(wordIdx) == W_SET);
    stb.enClr = stb.store && (int'(wordIdx) == W_CLR);
  end

  assign resetEdge = stb.store && (int'(wordIdx) == W_GEN)
                     && !oldSelfReset && newSelfReset;

  always_ff @(posedge clk) begin
    if (!rst_n) resetPulse <= 1'b0;
    else        resetPulse <= resetEdge;
  end
endmodule

// File: rtl/bcr_data.sv
module bcr_data
  import bcr_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int WORDS = NUM_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] rdData,
  output logic          selfResetBit,
  output logic [DW-1:0] mapCfg,
  output logic [DW-1:0] edgeMask,
  output logic [DW-1:0] polMask,
  output logic [DW-1:0] intEnable
);
  logic [DW-1:0] regFile [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (i == W_EN) begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n)         regFile[i] <= DW'(resetValue(i));
        else if (stb.enSet) regFile[i] <= regFile[i] | busWdata;
        else if (stb.enClr) regFile[i] <= regFile[i] & ~busWdata;
      end
    end else if (i == W_ISR) begin : g_isr
      assign regFile[i] = DW'(resetValue(i));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)
          regFile[i] <= DW'(resetValue(i));
        else if (stb.store && (int'(stb.idx) == i))
          regFile[i] <= busWdata;
      end
    end
  end

  assign rdData       = stb.rdHit ? regFile[stb.idx] : '0;
  assign selfResetBit = regFile[W_GEN][SELF_RESET_BIT];
  assign mapCfg       = regFile[W_MAP];
  assign edgeMask     = regFile[W_EDGE];
  assign polMask      = regFile[W_POL];
  assign intEnable    = regFile[W_EN];
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sysResetReq,
  output logic [DATA_W-1:0] mapCfg,
  output logic [DATA_W-1:0] edgeMask,
  output logic [DATA_W-1:0] polMask,
  output logic [DATA_W-1:0] intEnable
);
  strobe_t stb;
  logic    selfResetBit;

  bcr_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .busAddr      (busAddr),
    .busWrite     (busWrite),
    .newSelfReset (busWdata[SELF_RESET_BIT]),
    .oldSelfReset (selfResetBit),
    .stb          (stb),
    .resetPulse   (sysResetReq)
  );

  bcr_data #(.DW(DATA_W), .WORDS(NUM_WORDS)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .busWdata     (busWdata),
    .rdData       (busRdata),
    .selfResetBit (selfResetBit),
    .mapCfg       (mapCfg),
    .edgeMask     (edgeMask),
    .polMask      (polMask),
    .intEnable    (intEnable)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              sysResetReq,
  input logic [DATA_W-1:0] mapCfg,
  input logic [DATA_W-1:0] intEnable
);
  localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(W_GEN * 4);
  localparam logic [ADDR_W-1:0] A_MAP = ADDR_W'(W_MAP * 4);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(W_SET * 4);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(W_CLR * 4);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(W_EN * 4);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(W_ISR * 4);
  localparam int TOP_BYTE = NUM_WORDS * 4;

  a_r2_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
    busWrite && busAddr == A_SET |=> intEnable == ($past(intEnable) | $past(busWdata)));

  a_r3_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
    busWrite && busAddr == A_CLR |=> intEnable == ($past(intEnable) & ~$past(busWdata)));

  a_r4_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busWrite && (busAddr == A_EN || busAddr == A_ISR) |=> $stable(intEnable));

  a_r4_isr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busAddr == A_ISR |-> busRdata == '0);

  a_r5_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysResetReq) |-> $past(busWrite && busAddr == A_GEN && busWdata[SELF_RESET_BIT]));

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetReq |=> !sysResetReq);

  a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    int'(busAddr) >= TOP_BYTE |-> busRdata == '0);

  a_r9_misaligned_drop: assert property (@(posedge clk) disable iff (!rst_n)
    busWrite && busAddr[1:0] != 2'b00 |=> $stable(mapCfg) && $stable(intEnable));

  a_r10_map_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    busAddr == A_MAP |-> busRdata == mapCfg);
endmodule

bind bridge_ctl_regs bcr_checker u_bcr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busAddr     (busAddr),
  .busWrite    (busWrite),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .sysResetReq (sysResetReq),
  .mapCfg      (mapCfg),
  .intEnable   (intEnable)
);

// File: tb/test_bridge_ctl_regs.sv
module test_bridge_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, mapCfg, edgeMask, polMask, intEnable;
  logic        sysResetReq;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mdl [32];

  always #4 clk = ~clk;

  bridge_ctl_regs i_bridge_ctl_regs (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .sysResetReq(sysResetReq),
    .mapCfg(mapCfg), .edgeMask(edgeMask), .polMask(polMask), .intEnable(intEnable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [6:0] a);
    if (a[1:0] != 2'b00 || a[6:2] >= 5'd28) return 32'h0;
    return mdl[a[6:2]];
  endfunction

  task automatic checkMirrors();
    chk("R10 mapCfg", mapCfg, mdl[6]);
    chk("R10 edgeMask", edgeMask, mdl[9]);
    chk("R10 polMask", polMask, mdl[11]);
    chk("R10 intEnable", intEnable, mdl[14]);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic expPulse;
    int   idx;
    idx = int'(a[6:2]);
    expPulse = (a == 7'h04) && !mdl[1][2] && d[2];
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    if (a[1:0] == 2'b00 && idx < 28 && idx != 14 && idx != 15) begin
      mdl[idx] = d;
      if (idx == 12) mdl[14] = mdl[14] | d;
      if (idx == 13) mdl[14] = mdl[14] & ~d;
    end
    chk(expPulse ? "R5 request pulse" : "R6 no request", {31'b0, sysResetReq}, {31'b0, expPulse});
    @(negedge clk);
    chk("R5 pulse width", {31'b0, sysResetReq}, 32'h0);
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(req, busRdata, expRead(a));
  endtask

  task automatic sweepRead(input string req);
    for (int i = 0; i < 32; i++) rd(7'(i * 4), (i >= 28) ? "R8 undefined read" : req);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    mdl[0] = 32'h0000_0C40; mdl[1] = 32'h0000_1384; mdl[2] = 32'h2BFF_8010;
    mdl[3] = 32'h255E_0091; mdl[4] = 32'h0000_6140; mdl[7] = 32'h0000_01FF;
    mdl[8] = 32'h0000_01FF; mdl[26] = 32'h0000_0008; mdl[27] = 32'h1000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle after reset", {31'b0, sysResetReq}, 32'h0);
    sweepRead("R1 reset value");
    checkMirrors();

    // R7 / R8: write every word offset, then read all back
    for (int i = 0; i < 32; i++) wr(7'(i * 4), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
    sweepRead("R7 stored word");
    checkMirrors();

    // R2 / R3 / R4: enable set and clear ports and read-only words
    wr(7'h34, 32'hFFFF_FFFF);
    rd(7'h38, "R3 clear all");
    wr(7'h30, 32'h0000_0F0F);
    rd(7'h38, "R2 set bits");
    rd(7'h30, "R2 set word stored");
    wr(7'h30, 32'h8000_0010);
    rd(7'h38, "R2 second set");
    wr(7'h34, 32'h0000_0303);
    rd(7'h38, "R3 clear bits");
    rd(7'h34, "R3 clear word stored");
    wr(7'h38, 32'h1234_5678);
    rd(7'h38, "R4 enable write ignored");
    wr(7'h3C, 32'hFFFF_FFFF);
    rd(7'h3C, "R4 status reads zero");
    checkMirrors();

    // R5 / R6: reset request on bit 2 rising
    wr(7'h04, 32'h0000_0000);
    wr(7'h04, 32'h0000_0004);
    rd(7'h04, "R5 value stored");
    wr(7'h04, 32'h0000_0004);
    wr(7'h04, 32'hFFFF_FFFB);
    wr(7'h04, 32'hFFFF_FFFF);
    wr(7'h08, 32'h0000_0004);
    rd(7'h04, "R5 final value");

    // R9: misaligned accesses
    for (int k = 1; k < 4; k++) begin
      wr(7'(7'h18 + k), 32'hDEAD_0000 + 32'(k));
      rd(7'(7'h18 + k), "R9 misaligned read");
      wr(7'(7'h38 + k), 32'hFFFF_FFFF);
    end
    rd(7'h18, "R9 write dropped");
    rd(7'h38, "R9 enable untouched");

    // R8: undefined tail writes then full sweep
    for (int i = 28; i < 32; i++) wr(7'(i * 4), 32'hFFFF_FFFF);
    sweepRead("R7 final state");
    checkMirrors();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule